// File: doc/BRIEF.md
# Banked System Handler State Register

This block keeps the active, pending and enable flags for a fixed group of system exceptions behind one 32-bit control word. The group covers memory-manage, bus fault, usage fault, supervisor call, pend-service, tick timer, debug monitor, hard fault, NMI and secure fault. Most flags exist twice, once for each security state. A register write selects the copy by the security of the access. Each bit then passes through its own gate, which depends on the access security, the current processor security state and a "faults target Non-secure" input.

The exception logic changes flags during entry and return through a separate set/clear side port. That port wins over a register write in the same cycle. Reads are combinational and return the copy selected by the access security, merged with the single-copy flags that the reader may see. After every write, a one-cycle strobe tells downstream priority logic to re-arbitrate.

Top module: `sys_handler_state_reg`

## Requirements
- R1: After reset, every flag is 0, `rd_data_o` reads 0 in both security views, and `upd_o` is 0.
- R2: The banked flags live at these bits: memory-manage active 0, usage active 3, supervisor-call active 7, pend-service active 10, tick active 11, usage pending 12, memory-manage pending 13, supervisor-call pending 15, memory-manage enable 16, usage enable 18, hard-fault pending 21. A write with `acc_secure_i`=1 updates only the Secure copy, and a write with `acc_secure_i`=0 updates only the Non-secure copy. A read returns the copy selected by `acc_secure_i`.
- R3: The secure-fault flags have one copy (active bit 4, enable bit 19, pending bit 20). Only Secure accesses write them, and they read as 0 in the Non-secure view.
- R4: The bus-fault flags have one copy (active bit 1, pending bit 14, enable bit 17). A write changes them only when the access is Secure or `faults_ns_i`=1. In the Non-secure view they read as 0 unless `faults_ns_i`=1.
- R5: The debug-monitor active flag (bit 8) has one copy. Any write updates it, and both views read it.
- R6: The Secure hard-fault active flag (bit 2 of the Secure view) never changes through a register write. Only the side port changes it.
- R7: The NMI active flag (bit 5, one copy, visible in both views) and the Non-secure hard-fault active flag (bit 2 of the Non-secure view) are clear-only. A write sets neither of them. A write clears them only when `acc_secure_i`=0, `cpu_secure_i`=1, `faults_ns_i`=1 and the written bit is 0.
- R8: `upd_o` is 1 in exactly the cycle after each accepted write, and 0 otherwise.
- R9: In the same cycle, a side-port set or clear of a flag overrides a register write to that flag. Set wins over clear. The `hw_*_s_i` vectors address the Secure copy, the `hw_*_ns_i` vectors address the Non-secure copy, and a single-copy flag responds to either vector. Bit positions follow the register layout.
- R10: Bits 6, 9 and 22 to 31 always read as 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data, register layout |
| acc_secure_i | input | 1 | Security of the access (write target and read view) |
| cpu_secure_i | input | 1 | Processor is in Secure state |
| faults_ns_i | input | 1 | Faults target Non-secure |
| hw_set_s_i | input | 32 | Side-port set, Secure copy and single-copy flags |
| hw_clr_s_i | input | 32 | Side-port clear, Secure copy and single-copy flags |
| hw_set_ns_i | input | 32 | Side-port set, Non-secure copy and single-copy flags |
| hw_clr_ns_i | input | 32 | Side-port clear, Non-secure copy and single-copy flags |
| rd_data_o | output | 32 | Read-back of the selected view |
| upd_o | output | 1 | One-cycle strobe after a write |

## Verification
The assertions assume that `wr_en_i` and the side-port vectors are clean single-cycle values sampled on the clock edge. They also assume the security and routing inputs are stable around that edge. The write-protection properties only claim stability in cycles where the side port leaves the checked flag alone. The stimulus changes every input at the falling edge, drives side-port pulses for exactly one cycle, and holds the side port at zero during the write sequences that test the protection rules. The only exceptions are the cycles that deliberately overlap a write and a side-port event.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned NCOPY   = 3;  // 0: Non-secure, 1: Secure, 2: single copy
  localparam int unsigned CP_NS   = 0;
  localparam int unsigned CP_S    = 1;
  localparam int unsigned CP_SH   = 2;

  // bit positions
  localparam int unsigned B_MEM_ACT  = 0;
  localparam int unsigned B_BUS_ACT  = 1;
  localparam int unsigned B_HF_ACT   = 2;
  localparam int unsigned B_USG_ACT  = 3;
  localparam int unsigned B_SF_ACT   = 4;
  localparam int unsigned B_NMI_ACT  = 5;
  localparam int unsigned B_SVC_ACT  = 7;
  localparam int unsigned B_DBG_ACT  = 8;
  localparam int unsigned B_PSV_ACT  = 10;
  localparam int unsigned B_TCK_ACT  = 11;
  localparam int unsigned B_USG_PND  = 12;
  localparam int unsigned B_MEM_PND  = 13;
  localparam int unsigned B_BUS_PND  = 14;
  localparam int unsigned B_SVC_PND  = 15;
  localparam int unsigned B_MEM_ENA  = 16;
  localparam int unsigned B_BUS_ENA  = 17;
  localparam int unsigned B_USG_ENA  = 18;
  localparam int unsigned B_SF_ENA   = 19;
  localparam int unsigned B_SF_PND   = 20;
  localparam int unsigned B_HF_PND   = 21;

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  localparam logic [DW-1:0] M_BANK_WR =
      (ONE << B_MEM_ACT) | (ONE << B_USG_ACT) | (ONE << B_SVC_ACT) |
      (ONE << B_PSV_ACT) | (ONE << B_TCK_ACT) | (ONE << B_USG_PND) |
      (ONE << B_MEM_PND) | (ONE << B_SVC_PND) | (ONE << B_MEM_ENA) |
      (ONE << B_USG_ENA) | (ONE << B_HF_PND);
  localparam logic [DW-1:0] M_HF   = ONE << B_HF_ACT;
  localparam logic [DW-1:0] M_NMI  = ONE << B_NMI_ACT;
  localparam logic [DW-1:0] M_DBG  = ONE << B_DBG_ACT;
  localparam logic [DW-1:0] M_BUS  =
      (ONE << B_BUS_ACT) | (ONE << B_BUS_PND) | (ONE << B_BUS_ENA);
  localparam logic [DW-1:0] M_SF   =
      (ONE << B_SF_ACT) | (ONE << B_SF_ENA) | (ONE << B_SF_PND);

  localparam logic [DW-1:0] M_BANK_IMPL = M_BANK_WR | M_HF;
  localparam logic [DW-1:0] M_SH_IMPL   = M_BUS | M_SF | M_DBG | M_NMI;
  localparam logic [DW-1:0] M_IMPL      = M_BANK_IMPL | M_SH_IMPL;
endpackage

// File: rtl/shr_wmask.sv
module shr_wmask
  import shr_pkg::*;
(
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          acc_secure_i,
  input  logic          cpu_secure_i,
  input  logic          faults_ns_i,
  output logic [DW-1:0] wm_ns_o,
  output logic [DW-1:0] wm_s_o,
  output logic [DW-1:0] wm_sh_o
);
  logic clr_ok;
  logic [DW-1:0] zero_bits;

  // clear path for NMI / Non-secure hard fault: only via Non-secure alias from Secure state
  assign clr_ok    = !acc_secure_i && cpu_secure_i && faults_ns_i;
  assign zero_bits = ~wr_data_i;

  always_comb begin
    wm_ns_o = '0;
    wm_s_o  = '0;
    wm_sh_o = '0;
    if (wr_en_i) begin
      if (acc_secure_i) begin
        wm_s_o = M_BANK_WR;
        wm_sh_o = wm_sh_o | M_SF;
      end else begin
        wm_ns_o = M_BANK_WR | (clr_ok ? (M_HF & zero_bits) : '0);
        wm_sh_o = wm_sh_o | (clr_ok ? (M_NMI & zero_bits) : '0);
      end
      if (acc_secure_i || faults_ns_i) wm_sh_o = wm_sh_o | M_BUS;
      wm_sh_o = wm_sh_o | M_DBG;
    end
  end
endmodule

// File: rtl/shr_flag_copy.sv
module shr_flag_copy
  import shr_pkg::*;
#(
  parameter logic [DW-1:0] IMPL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wr_mask_i,
  input  logic [DW-1:0] wr_val_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q, nxt;

  // side port first (set over clear), then register write, else hold
  always_comb begin
    nxt = (q_q & ~wr_mask_i) | (wr_val_i & wr_mask_i);
    nxt = nxt & ~clr_i;
    nxt = nxt | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt & IMPL;
  end

  assign q_o = q_q;
endmodule

// File: rtl/shr_rdmux.sv
module shr_rdmux
  import shr_pkg::*;
(
  input  logic          acc_secure_i,
  input  logic          faults_ns_i,
  input  logic [DW-1:0] q_ns_i,
  input  logic [DW-1:0] q_s_i,
  input  logic [DW-1:0] q_sh_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] ns_vis;
  assign ns_vis = M_DBG | M_NMI | (faults_ns_i ? M_BUS : '0);
  assign rd_o = acc_secure_i ? (q_s_i | q_sh_i) : (q_ns_i | (q_sh_i & ns_vis));
endmodule

// File: rtl/sys_handler_state_reg.sv
module sys_handler_state_reg
  import shr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [31:0]   wr_data_i,
  input  logic          acc_secure_i,
  input  logic          cpu_secure_i,
  input  logic          faults_ns_i,
  input  logic [31:0]   hw_set_s_i,
  input  logic [31:0]   hw_clr_s_i,
  input  logic [31:0]   hw_set_ns_i,
  input  logic [31:0]   hw_clr_ns_i,
  output logic [31:0]   rd_data_o,
  output logic          upd_o
);
  logic [DW-1:0] wm   [NCOPY];
  logic [DW-1:0] setv [NCOPY];
  logic [DW-1:0] clrv [NCOPY];
  logic [DW-1:0] flg  [NCOPY];
  logic          upd_q;

  shr_wmask u_wmask (
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .acc_secure_i (acc_secure_i),
    .cpu_secure_i (cpu_secure_i),
    .faults_ns_i  (faults_ns_i),
    .wm_ns_o      (wm[CP_NS]),
    .wm_s_o       (wm[CP_S]),
    .wm_sh_o      (wm[CP_SH])
  );

  assign setv[CP_NS] = hw_set_ns_i;
  assign clrv[CP_NS] = hw_clr_ns_i;
  assign setv[CP_S]  = hw_set_s_i;
  assign clrv[CP_S]  = hw_clr_s_i;
  assign setv[CP_SH] = hw_set_s_i | hw_set_ns_i;
  assign clrv[CP_SH] = hw_clr_s_i | hw_clr_ns_i;

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    localparam logic [DW-1:0] IMPL_K = (k == CP_SH) ? M_SH_IMPL : M_BANK_IMPL;
    shr_flag_copy #(.IMPL(IMPL_K)) u_copy (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_mask_i (wm[k]),
      .wr_val_i  (wr_data_i),
      .set_i     (setv[k]),
      .clr_i     (clrv[k]),
      .q_o       (flg[k])
    );
  end

  shr_rdmux u_rdmux (
    .acc_secure_i (acc_secure_i),
    .faults_ns_i  (faults_ns_i),
    .q_ns_i       (flg[CP_NS]),
    .q_s_i        (flg[CP_S]),
    .q_sh_i       (flg[CP_SH]),
    .rd_o         (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= wr_en_i;
  end
  assign upd_o = upd_q;
endmodule

// File: rtl/shr_checker.sv
module shr_checker
  import shr_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          acc_secure_i,
  input logic          faults_ns_i,
  input logic [31:0]   hw_set_s_i,
  input logic [31:0]   hw_clr_s_i,
  input logic [31:0]   hw_set_ns_i,
  input logic [31:0]   hw_clr_ns_i,
  input logic [31:0]   rd_data_o,
  input logic          upd_o,
  input logic [31:0]   s_q,
  input logic [31:0]   sh_q
);
  logic [31:0] hw_any;
  assign hw_any = hw_set_s_i | hw_clr_s_i | hw_set_ns_i | hw_clr_ns_i;

  a_r8_upd_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> upd_o);
  a_r8_no_spurious_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !upd_o);
  a_r6_sec_hf_act_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hw_set_s_i[B_HF_ACT] && !hw_clr_s_i[B_HF_ACT]) |=> $stable(s_q[B_HF_ACT]));
  a_r3_sf_ns_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_secure_i && ((hw_any & M_SF) == '0)) |=> $stable(sh_q & M_SF));
  a_r4_bus_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !acc_secure_i && !faults_ns_i && ((hw_any & M_BUS) == '0))
      |=> $stable(sh_q & M_BUS));
  a_r7_nmi_never_set_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_set_s_i[B_NMI_ACT] && !hw_set_ns_i[B_NMI_ACT]) |=> !$rose(sh_q[B_NMI_ACT]));
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_set_s_i[B_MEM_ACT] |=> s_q[B_MEM_ACT]);
  a_r9_clr_over_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_s_i[B_USG_ACT] && !hw_set_s_i[B_USG_ACT]) |=> !s_q[B_USG_ACT]);
  a_r10_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~M_IMPL) == '0);
endmodule

bind sys_handler_state_reg shr_checker u_shr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .acc_secure_i (acc_secure_i),
  .faults_ns_i  (faults_ns_i),
  .hw_set_s_i   (hw_set_s_i),
  .hw_clr_s_i   (hw_clr_s_i),
  .hw_set_ns_i  (hw_set_ns_i),
  .hw_clr_ns_i  (hw_clr_ns_i),
  .rd_data_o    (rd_data_o),
  .upd_o        (upd_o),
  .s_q          (flg[1]),
  .sh_q         (flg[2])
);

// File: tb/sys_handler_state_reg_test.sv
module sys_handler_state_reg_test;
  localparam logic [31:0] BWR = (32'd1<<0)|(32'd1<<3)|(32'd1<<7)|(32'd1<<10)|(32'd1<<11)|
                                (32'd1<<12)|(32'd1<<13)|(32'd1<<15)|(32'd1<<16)|(32'd1<<18)|
                                (32'd1<<21);
  localparam logic [31:0] BUS = (32'd1<<1)|(32'd1<<14)|(32'd1<<17);
  localparam logic [31:0] SF  = (32'd1<<4)|(32'd1<<19)|(32'd1<<20);
  localparam logic [31:0] DBG = 32'd1<<8;
  localparam logic [31:0] NMI = 32'd1<<5;
  localparam logic [31:0] HF  = 32'd1<<2;
  localparam logic [31:0] UNI = (32'd1<<6)|(32'd1<<9)|32'hFFC0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, acc_s = 1'b0, cpu_s = 1'b0, fns = 1'b0;
  logic [31:0] wdata = '0, set_s = '0, clr_s = '0, set_ns = '0, clr_ns = '0;
  logic [31:0] rdata;
  logic upd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sys_handler_state_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata),
    .acc_secure_i(acc_s), .cpu_secure_i(cpu_s), .faults_ns_i(fns),
    .hw_set_s_i(set_s), .hw_clr_s_i(clr_s), .hw_set_ns_i(set_ns), .hw_clr_ns_i(clr_ns),
    .rd_data_o(rdata), .upd_o(upd)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic sec, logic f, logic [31:0] exp);
    acc_s = sec; fns = f; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(logic sec, logic cpu, logic f, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; acc_s = sec; cpu_s = cpu; fns = f; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; set_s = '0; clr_s = '0; set_ns = '0; clr_ns = '0;
  endtask

  task automatic t_reset;
    rd("R1 secure view", 1'b1, 1'b1, 32'h0);
    rd("R1 ns view", 1'b0, 1'b1, 32'h0);
    chk("R1 upd", {31'b0, upd}, 32'h0);
  endtask

  task automatic t_banking;
    wr(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd("R2 R3 R4 R5 secure all-ones", 1'b1, 1'b0, BWR | BUS | SF | DBG);
    rd("R3 R4 R5 ns view hides", 1'b0, 1'b0, DBG);
    rd("R4 ns view bus visible", 1'b0, 1'b1, DBG | BUS);
    wr(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd("R2 R7 ns all-ones", 1'b0, 1'b0, BWR | DBG);
    rd("R2 secure untouched", 1'b1, 1'b0, BWR | BUS | SF | DBG);
    chk("R10 unimplemented", rdata & UNI, 32'h0);
    wr(1'b0, 1'b0, 1'b1, 32'h0);
    rd("R2 R4 R5 ns zero write", 1'b0, 1'b1, 32'h0);
    rd("R3 R4 sf kept bus cleared", 1'b1, 1'b1, BWR | SF);
  endtask

  task automatic t_upd;
    @(negedge clk);
    wr_en = 1'b1; acc_s = 1'b1; wdata = BWR | SF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 strobe after write", {31'b0, upd}, 32'h1);
    @(negedge clk);
    chk("R8 strobe one cycle", {31'b0, upd}, 32'h0);
  endtask

  task automatic t_clear_only;
    @(negedge clk);
    set_s = HF | NMI; set_ns = HF;
    @(negedge clk);
    set_s = '0; set_ns = '0;
    rd("R6 R7 side set secure", 1'b1, 1'b1, BWR | SF | HF | NMI);
    wr(1'b1, 1'b1, 1'b1, 32'h0);
    rd("R6 secure hf stays", 1'b1, 1'b1, HF | NMI);
    wr(1'b0, 1'b0, 1'b1, 32'h0);
    rd("R7 cpu ns no clear", 1'b0, 1'b1, HF | NMI);
    wr(1'b0, 1'b1, 1'b0, 32'h0);
    rd("R7 faults_ns=0 no clear", 1'b0, 1'b1, HF | NMI);
    wr(1'b0, 1'b1, 1'b1, HF | NMI);
    rd("R7 written one no clear", 1'b0, 1'b1, HF | NMI);
    wr(1'b0, 1'b1, 1'b1, 32'h0);
    rd("R7 clear ns view", 1'b0, 1'b1, 32'h0);
    rd("R6 R7 secure hf kept nmi gone", 1'b1, 1'b1, HF);
  endtask

  task automatic t_side_priority;
    set_s = 32'h1;
    wr(1'b1, 1'b1, 1'b0, 32'h0);
    rd("R9 set over write zero", 1'b1, 1'b0, HF | 32'h1);
    clr_s = 32'h8;
    wr(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
    rd("R9 clear over write one", 1'b1, 1'b0, (BWR & ~32'h8) | HF | BUS | SF | DBG);
    set_s = 32'h80; clr_s = 32'h80;
    wr(1'b1, 1'b1, 1'b0, 32'h0);
    rd("R9 set beats clear", 1'b1, 1'b0, HF | 32'h80);
    chk("R10 unimplemented after writes", rdata & UNI, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_banking();
    t_upd();
    t_clear_only();
    t_side_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule